// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers reset requests from seven origins and turns them into four reset lines. The origins are power-up, the external reset pin, a watchdog timeout, a halt monitor, loss of the clock reference, test-mode entry and a processor reset instruction. The four lines are an external-pin reset, a clock-module reset, a master reset for internal logic and a system-reset indication. Every request is sampled on the rising edge of the system clock, so all outputs change only on that edge.

Requests fall into two classes. Asynchronous requests (power-up, watchdog, halt monitor, processor instruction) start a reset on the next edge, whatever the bus is doing. Synchronous requests (external pin, clock loss, test mode) are held pending until the current bus cycle ends. While a synchronous request is pending, the bus monitor is forced on so that a cycle that never ends is still closed. Each origin drives its own subset of the lines. Once asserted, the lines stay active for a fixed number of cycles and are then released together. On the release edge of the master reset, the mode-select pins are captured as the operating configuration. A cause register records which origins started the most recent reset.

Top module: `rst_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_ext`, `rst_clk` and `rst_mst` are high and `rst_sys` is low. After `por_n` rises, these lines stay high for exactly HOLD_CYC (default 16) more rising edges.
- R2: A watchdog (src_req bit 1), halt-monitor (bit 2) or processor-instruction (bit 5) request sampled on a rising edge asserts its lines on that same edge, even when `bus_done` is low.
- R3: An external-pin (src_req bit 0), clock-loss (bit 3) or test-mode (bit 4) request asserts no line until `bus_done` is sampled high. While such a request waits, `bus_mon_force` is high. Several synchronous requests that arrive while waiting are merged into one reset.
- R4: Every origin except the processor instruction asserts `rst_ext` and `rst_mst`. Every origin except the processor instruction and clock loss also asserts `rst_clk`. When several origins start a reset together, the lines are the union of their subsets.
- R5: A reset started only by the processor instruction asserts `rst_ext` and `rst_sys`, and leaves `rst_mst` and `rst_clk` low.
- R6: A reset started only by clock loss asserts `rst_ext` and `rst_mst`, and leaves `rst_clk` low.
- R7: A requested reset keeps its lines active for exactly HOLD_CYC cycles. All lines then fall on the same edge.
- R8: On the edge where `rst_mst` falls, `cfg_data`, `cfg_clk_sel` and `cfg_brk_mode` take the values of `cfg_data_pins`, `cfg_clk_pin` and `cfg_brk_pin`. They do not change on any other edge. A reset without the master line does not update them.
- R9: `rst_cause` holds one bit per origin: bit 0 power-up, bit 1 external pin, bit 2 watchdog, bit 3 halt, bit 4 clock loss, bit 5 test, bit 6 processor instruction. It is rewritten with exactly the origins that start each reset. Power-up leaves only bit 0 set.
- R10: When an asynchronous request arrives while synchronous ones are pending, or in the same cycle as them, only the asynchronous origins start the reset. The pending synchronous requests are discarded.
- R11: Requests sampled while the lines are active are ignored. They neither extend the reset nor change `rst_cause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that qualifies every request |
| por_n | input | 1 | Power-up request, active low, asynchronous |
| src_req | input | 6 | Requests: 0 ext pin, 1 watchdog, 2 halt, 3 clock loss, 4 test, 5 processor instruction |
| bus_done | input | 1 | Current bus cycle has ended (normally or by the monitor) |
| cfg_data_pins | input | CFG_W | Data pins sampled as configuration |
| cfg_clk_pin | input | 1 | Clock-source select pin |
| cfg_brk_pin | input | 1 | Breakpoint-behaviour select pin |
| rst_ext | output | 1 | External pin reset |
| rst_clk | output | 1 | Clock-module reset |
| rst_mst | output | 1 | Master reset for internal logic |
| rst_sys | output | 1 | System-reset indication from the processor instruction |
| bus_mon_force | output | 1 | Bus monitor forced on while a synchronous reset waits |
| rst_cause | output | 7 | Origins of the most recent reset |
| cfg_data | output | CFG_W | Latched data-pin configuration |
| cfg_clk_sel | output | 1 | Latched clock-source select |
| cfg_brk_mode | output | 1 | Latched breakpoint mode |

## Verification
The asynchronous-start path and the synchronous-release path can both fire on one edge. This happens when a watchdog or halt request lands while a pin, clock-loss or test request is pending, or in the same cycle as one. The bench provokes this both with `bus_done` held low and with it high. It judges the result by checking that the lines and `rst_cause` reflect only the asynchronous origins and that no second reset follows once the bus cycle ends. A second overlap, a fresh request during an active hold, is checked by counting the total hold length and reading the cause afterwards.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
package rstc_pkg;
  localparam int NSRC  = 7;
  localparam int NLINE = 4;

  // origin indices (also the cause bit positions)
  localparam int S_PWR  = 0;
  localparam int S_PIN  = 1;
  localparam int S_WDOG = 2;
  localparam int S_HALT = 3;
  localparam int S_LOC  = 4;
  localparam int S_TEST = 5;
  localparam int S_CPU  = 6;

  // line indices
  localparam int L_EXT = 0;
  localparam int L_CLK = 1;
  localparam int L_MST = 2;
  localparam int L_SYS = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_HOLD} rstc_state_e;

  function automatic logic src_is_async(input int s);
    return (s == S_PWR) || (s == S_WDOG) || (s == S_HALT) || (s == S_CPU);
  endfunction

  // subset of lines driven by one origin, {sys,mst,clk,ext}
  function automatic logic [NLINE-1:0] src_lines(input int s);
    case (s)
      S_CPU:   return 4'b1001;
      S_LOC:   return 4'b0101;
      default: return 4'b0111;
    endcase
  endfunction

  function automatic logic [NLINE-1:0] lines_of_set(input logic [NSRC-1:0] set);
    logic [NLINE-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++)
      if (set[s]) m = m | src_lines(s);
    return m;
  endfunction
endpackage

// File: rtl/rstc_classify.sv
`timescale 1ns/1ps
module rstc_classify
  import rstc_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output logic [NSRC-1:0] async_hit,
  output logic [NSRC-1:0] sync_hit
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if (src_is_async(s)) begin : g_a
      assign async_hit[s] = req[s];
      assign sync_hit[s]  = 1'b0;
    end else begin : g_s
      assign async_hit[s] = 1'b0;
      assign sync_hit[s]  = req[s];
    end
  end
endmodule

// File: rtl/rstc_hold_timer.sv
`timescale 1ns/1ps
module rstc_hold_timer #(
  parameter int HOLD_CYC = 16,
  localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          start,
  input  logic          active,
  output logic [CW-1:0] cnt,
  output logic          last
);
  assign last = active && (cnt == CW'(HOLD_CYC - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               cnt <= '0;
    else if (start)           cnt <= '0;
    else if (active && !last) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rstc_cfg_latch.sv
`timescale 1ns/1ps
module rstc_cfg_latch #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             capture,
  input  logic [CFG_W-1:0] data_pins,
  input  logic             clk_pin,
  input  logic             brk_pin,
  output logic [CFG_W-1:0] data_q,
  output logic             clk_q,
  output logic             brk_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      data_q <= '0;
      clk_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else if (capture) begin
      data_q <= data_pins;
      clk_q  <= clk_pin;
      brk_q  <= brk_pin;
    end
  end
endmodule

// File: rtl/rst_ctrl.sv
`timescale 1ns/1ps
module rst_ctrl
  import rstc_pkg::*;
#(
  parameter int HOLD_CYC = 16,
  parameter int CFG_W    = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [NSRC-2:0]  src_req,
  input  logic             bus_done,
  input  logic [CFG_W-1:0] cfg_data_pins,
  input  logic             cfg_clk_pin,
  input  logic             cfg_brk_pin,
  output logic             rst_ext,
  output logic             rst_clk,
  output logic             rst_mst,
  output logic             rst_sys,
  output logic             bus_mon_force,
  output logic [NSRC-1:0]  rst_cause,
  output logic [CFG_W-1:0] cfg_data,
  output logic             cfg_clk_sel,
  output logic             cfg_brk_mode
);
  localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;

  rstc_state_e      state;
  logic [NLINE-1:0] lines_q;
  logic [NSRC-1:0]  pend_q;
  logic [NSRC-1:0]  req_vec, a_hit, s_hit, sync_set, start_set;
  logic             async_go, sync_go, start_rst, hold_last, cfg_cap;
  logic [CW-1:0]    hold_cnt;

  assign req_vec = {src_req, 1'b0};

  rstc_classify u_cls (
    .req       (req_vec),
    .async_hit (a_hit),
    .sync_hit  (s_hit)
  );

  // named events
  assign sync_set  = pend_q | s_hit;
  assign async_go  = (state != ST_HOLD) && (|a_hit);
  assign sync_go   = !async_go && (state != ST_HOLD) && (|sync_set) && bus_done;
  assign start_rst = async_go || sync_go;
  assign start_set = async_go ? a_hit : sync_set;
  assign cfg_cap   = hold_last && lines_q[L_MST];

  rstc_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk    (clk),
    .por_n  (por_n),
    .start  (start_rst),
    .active (state == ST_HOLD),
    .cnt    (hold_cnt),
    .last   (hold_last)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state     <= ST_HOLD;
      lines_q   <= src_lines(S_PWR);
      rst_cause <= NSRC'(1) << S_PWR;
      pend_q    <= '0;
    end else if (start_rst) begin
      state     <= ST_HOLD;
      lines_q   <= lines_of_set(start_set);
      rst_cause <= start_set;
      pend_q    <= '0;
    end else if (state == ST_HOLD) begin
      if (hold_last) begin
        state   <= ST_IDLE;
        lines_q <= '0;
      end
    end else if (|sync_set) begin
      state  <= ST_PEND;
      pend_q <= sync_set;
    end
  end

  assign rst_ext       = lines_q[L_EXT];
  assign rst_clk       = lines_q[L_CLK];
  assign rst_mst       = lines_q[L_MST];
  assign rst_sys       = lines_q[L_SYS];
  assign bus_mon_force = (state == ST_PEND);

  rstc_cfg_latch #(.CFG_W(CFG_W)) u_cfg (
    .clk       (clk),
    .por_n     (por_n),
    .capture   (cfg_cap),
    .data_pins (cfg_data_pins),
    .clk_pin   (cfg_clk_pin),
    .brk_pin   (cfg_brk_pin),
    .data_q    (cfg_data),
    .clk_q     (cfg_clk_sel),
    .brk_q     (cfg_brk_mode)
  );

  // ---------------- assertions ----------------
  a_r2_async_now: assert property (@(posedge clk) disable iff (!por_n)
    async_go |=> (rst_ext && rst_cause == $past(a_hit)));

  a_r3_sync_waits: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_PEND && !bus_done && !(|a_hit)) |=> (!rst_ext && bus_mon_force));

  a_r3_monitor_quiet: assert property (@(posedge clk) disable iff (!por_n)
    bus_mon_force |-> !(rst_ext || rst_mst || rst_clk || rst_sys));

  a_r4_clk_needs_master: assert property (@(posedge clk) disable iff (!por_n)
    rst_clk |-> rst_mst);

  a_r5_sys_from_cpu: assert property (@(posedge clk) disable iff (!por_n)
    rst_sys |-> rst_cause[S_CPU]);

  a_r7_hold_length: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_ext) |-> ($past(hold_cnt) == CW'(HOLD_CYC - 1)));

  a_r7_release_together: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_ext) |-> !(rst_clk || rst_mst || rst_sys));

  a_r8_cfg_stable: assert property (@(posedge clk) disable iff (!por_n)
    !cfg_cap |=> ($stable(cfg_data) && $stable(cfg_clk_sel) && $stable(cfg_brk_mode)));

  a_r10_async_wins: assert property (@(posedge clk) disable iff (!por_n)
    (async_go && (|sync_set)) |=> !(rst_cause[S_PIN] || rst_cause[S_LOC] || rst_cause[S_TEST]));

  a_r11_hold_ignores: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_HOLD && !hold_last) |=> $stable(rst_cause));
endmodule

// File: tb/rst_ctrl_test.sv
`timescale 1ns/1ps
module rst_ctrl_test;
  localparam int H  = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          por_n;
  logic [5:0]    src_req;
  logic          bus_done;
  logic [CW-1:0] pins;
  logic          clk_pin, brk_pin;
  logic          rst_ext, rst_clk, rst_mst, rst_sys, bus_mon_force;
  logic [6:0]    rst_cause;
  logic [CW-1:0] cfg_data;
  logic          cfg_clk_sel, cfg_brk_mode;

  int n_tests = 0;
  int n_fail  = 0;
  logic [CW+1:0] cfg_exp;

  always #2.5 clk = ~clk;

  rst_ctrl #(.HOLD_CYC(H), .CFG_W(CW)) uut (
    .clk(clk), .por_n(por_n), .src_req(src_req), .bus_done(bus_done),
    .cfg_data_pins(pins), .cfg_clk_pin(clk_pin), .cfg_brk_pin(brk_pin),
    .rst_ext(rst_ext), .rst_clk(rst_clk), .rst_mst(rst_mst), .rst_sys(rst_sys),
    .bus_mon_force(bus_mon_force), .rst_cause(rst_cause),
    .cfg_data(cfg_data), .cfg_clk_sel(cfg_clk_sel), .cfg_brk_mode(cfg_brk_mode)
  );

  wire [3:0]    lines   = {rst_sys, rst_mst, rst_clk, rst_ext};
  wire [CW+1:0] cfg_now = {cfg_brk_mode, cfg_clk_sel, cfg_data};

  // expected line subset for a set of origins, {sys,mst,clk,ext}
  function automatic logic [3:0] exp_lines(input logic [6:0] set);
    logic ext, clkr, mst, sys;
    ext  = |set;
    mst  = |(set & 7'b0111111);
    clkr = |(set & 7'b0101111);
    sys  = set[6];
    return {sys, mst, clkr, ext};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one request pulse across one rising edge
  task automatic fire(input logic [5:0] r, input logic bd);
    src_req  = r;
    bus_done = bd;
    step(1);
    src_req  = '0;
  endtask

  // count asserted cycles, starting from n0 already seen
  task automatic hold_len(input string rq, input logic [3:0] m, input int n0);
    int  n;
    bit  bad;
    n = n0;
    bad = 0;
    while (lines != 4'b0 && n < H + 4) begin
      step(1);
      if (lines != 4'b0) begin
        if (lines !== m) bad = 1;
        n++;
      end
    end
    chk({rq, " hold length"}, n, H);
    chk({rq, " lines constant"}, bad, 0);
  endtask

  task automatic set_pins(input int seed);
    pins    = CW'(seed * 37 + 11);
    clk_pin = seed[0];
    brk_pin = seed[1];
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] set;
    por_n = 1'b0; src_req = '0; bus_done = 1'b1;
    pins = 8'hA5; clk_pin = 1'b1; brk_pin = 1'b0;
    step(3);
    chk("R1 lines during power-up", lines, 4'b0111);
    chk("R9 cause after power-up", rst_cause, 7'h01);
    por_n = 1'b1;
    hold_len("R1", 4'b0111, 1);
    cfg_exp = {1'b0, 1'b1, 8'hA5};
    chk("R8 cfg latched at power-up release", cfg_now, cfg_exp);
    pins = 8'h3C; clk_pin = 1'b0; brk_pin = 1'b1;
    step(3);
    chk("R8 cfg unchanged while idle", cfg_now, cfg_exp);

    // sweep every single origin, bus idle
    for (int k = 1; k <= 6; k++) begin
      string tg;
      tg = (k == 6) ? "R5" : (k == 4) ? "R6" : (k == 2 || k == 3) ? "R2" : "R3";
      set = 7'(1) << k;
      set_pins(k);
      fire(6'(1) << (k - 1), 1'b1);
      chk({tg, " R4 lines single origin"}, lines, exp_lines(set));
      chk("R9 cause single origin", rst_cause, set);
      hold_len("R7 single origin", exp_lines(set), 1);
      if (exp_lines(set) & 4'b0100) cfg_exp = {brk_pin, clk_pin, pins};
      chk("R8 cfg after single origin", cfg_now, cfg_exp);
      step(2);
    end

    // every combination of asynchronous origins, bus busy
    for (int c = 1; c < 8; c++) begin
      logic [2:0] cb;
      cb  = 3'(c);
      set = {cb[2], 2'b00, cb[1], cb[0], 2'b00};
      set_pins(c + 10);
      fire(set[6:1], 1'b0);
      chk("R2 R4 async combo lines with bus busy", lines, exp_lines(set));
      chk("R9 async combo cause", rst_cause, set);
      hold_len("R7 async combo", exp_lines(set), 1);
      if (exp_lines(set) & 4'b0100) cfg_exp = {brk_pin, clk_pin, pins};
      chk("R8 cfg after async combo", cfg_now, cfg_exp);
      step(2);
    end

    // synchronous origins wait for end of bus cycle and merge
    fire(6'b000001, 1'b0);
    chk("R3 no lines while pending", lines, 4'b0);
    chk("R3 monitor forced", bus_mon_force, 1'b1);
    fire(6'b010000, 1'b0);
    step(3);
    chk("R3 still waiting", lines, 4'b0);
    set_pins(99);
    bus_done = 1'b1;
    step(1);
    chk("R3 lines after bus cycle end", lines, exp_lines(7'b0100010));
    chk("R3 R9 merged cause", rst_cause, 7'b0100010);
    chk("R3 monitor released", bus_mon_force, 1'b0);
    hold_len("R7 sync", exp_lines(7'b0100010), 1);
    cfg_exp = {brk_pin, clk_pin, pins};
    chk("R8 cfg after sync", cfg_now, cfg_exp);
    step(2);

    // asynchronous overrides a pending synchronous request
    fire(6'b001000, 1'b0);
    chk("R10 loss pending monitor", bus_mon_force, 1'b1);
    fire(6'b000010, 1'b0);
    chk("R10 async lines win", lines, 4'b0111);
    chk("R10 async cause only", rst_cause, 7'b0000100);
    hold_len("R10", 4'b0111, 1);
    bus_done = 1'b1;
    step(3);
    chk("R10 pending discarded", lines, 4'b0);
    chk("R10 monitor idle", bus_mon_force, 1'b0);

    // same-cycle sync and async
    fire(6'b010100, 1'b1);
    chk("R10 same-cycle cause", rst_cause, 7'b0001000);
    hold_len("R10 same-cycle", 4'b0111, 1);
    step(3);
    chk("R10 no follow-up reset", lines, 4'b0);

    // requests during hold are ignored
    fire(6'b000010, 1'b1);
    step(4);
    fire(6'b100000, 1'b1);
    fire(6'b000001, 1'b1);
    chk("R11 lines unaffected", lines, 4'b0111);
    hold_len("R11", 4'b0111, 7);
    chk("R11 cause unchanged", rst_cause, 7'b0000100);
    step(3);
    chk("R11 no reset after release", lines, 4'b0);

    // cpu reset then power-up clears cause
    fire(6'b100000, 1'b1);
    hold_len("R5 cpu", 4'b1001, 1);
    chk("R5 cause cpu", rst_cause, 7'b1000000);
    step(2);
    por_n = 1'b0;
    step(1);
    chk("R9 power-up clears other bits", rst_cause, 7'h01);
    chk("R1 lines second power-up", lines, 4'b0111);
    por_n = 1'b1;
    hold_len("R1 second", 4'b0111, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule